// File: doc/BRIEF.md
# RC4 Stream Cipher Engine

This unit encrypts or decrypts a byte stream with the RC4 algorithm under host control through a flat word-addressed register port. After reset it fills its 256-byte state array with the identity permutation. The host then writes up to sixteen key bytes and a key length, which starts the key-driven scrambling of the state. Data then goes in as 32-bit sub-messages: each word is four bytes, byte 0 in bits 7:0 and processed first. The unit XORs each byte with the next keystream byte and leaves the result in a cipher register. A one-word input buffer lets the host load the next word while the current one is being processed.

Every phase end raises its own status flag and a pending-interrupt bit. The pending bit drives the interrupt pin only when the host enables it. After the word marked last finishes, the unit re-initializes its state array on its own, so a new key can follow. The state array and the i/j indices can be saved and restored through a context window while no phase is running; context writes during a running phase are dropped.

Top module: `rc4_unit`

## Requirements
- R1: The status register is read at word address 0x401 with bit 0 busy, bit 1 interrupt pending, bit 2 initialize done, bit 3 permute done, bit 4 sub-message done, bit 5 full message done, bit 6 input buffer empty, and bits 31:7 zero. It reads zero while reset is held.
- R2: One cycle after reset is released, initialization starts. It writes S[k]=k for 256 cycles with busy set, then sets initialize done and drops busy in the following cycle.
- R3: A write to the key-length register (0x404) with a value from 1 to 16 while initialize done is set clears initialize done and starts a 256-cycle permutation (busy set) that ends by setting permute done. Values 0 and above 16 are ignored.
- R4: A write to the message register (0x408) fills the buffer, which clears input buffer empty, permute done and sub-message done. Input buffer empty sets again when the engine takes the word.
- R5: Each message word comes back from the cipher register (0x40C) as the word XOR the next four RC4 keystream bytes, byte 0 in bits 7:0, and the stream continues across words. Key byte n is bits 8*(n mod 4)+7:8*(n mod 4) of key word 0x410 + n/4.
- R6: Sub-message done sets when a word finishes. Full message done sets when a word written while control bit 1 (last) was set finishes. Full message done clears on a read of the cipher register or on a key or key-length write.
- R7: After the last word finishes, the engine runs initialization again and sets initialize done, ready for a new key.
- R8: Initialize, permute, sub-message and full message completion each set the pending bit. A status read clears it, but a completion in the same cycle as the read leaves it set.
- R9: The interrupt output is the pending bit gated by control bit 0 at address 0x400. The control register resets to zero, so the output stays low after reset until the enable bit is written.
- R10: Address 0x500+k reads and writes S[k], and address 0x600 reads and writes i in bits 15:8 and j in bits 7:0. Any context access makes busy read 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Word address of the access |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; carries read side effects |
| rd_data | output | 32 | Read data of the addressed register (combinational) |
| irq | output | 1 | Interrupt request, pending bit gated by the enable |

## Verification
The conflict that matters is a status read landing in the same cycle as a phase completion: the read tries to clear the pending bit while the completion tries to set it. The bench provokes this by polling the status register on every cycle while a sub-message is processed, so one of the reads always straddles the completion edge. It judges the outcome by requiring the first read that shows sub-message done to also show the pending bit. If the clear took priority, that read would show sub-message done with the pending bit already gone.

// File: rtl/rc4_unit.sv
`timescale 1ns/1ps
module rc4_unit #(
  parameter int AW      = 11,
  parameter int KEY_MAX = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic          rd_en,
  output logic [31:0]   rd_data,
  output logic          irq
);
  localparam int KWORDS = (KEY_MAX + 3) / 4;
  localparam int KIW    = $clog2(KEY_MAX);
  localparam int KLW    = $clog2(KEY_MAX + 1);
  localparam logic [AW-1:0] A_CTRL = AW'('h400);
  localparam logic [AW-1:0] A_STAT = AW'('h401);
  localparam logic [AW-1:0] A_KLEN = AW'('h404);
  localparam logic [AW-1:0] A_MSG  = AW'('h408);
  localparam logic [AW-1:0] A_CIPH = AW'('h40C);
  localparam logic [AW-1:0] A_KEY  = AW'('h410);
  localparam logic [AW-1:0] A_CTX  = AW'('h500);
  localparam logic [AW-1:0] A_IJ   = AW'('h600);

  typedef enum logic [2:0] {S_BOOT, S_INIT, S_KEYW, S_PERM, S_MSGW, S_MSG} st_t;

  st_t            st;
  logic [7:0]     s [256];
  logic [7:0]     key_b [KEY_MAX];
  logic [7:0]     i, j;
  logic [KIW-1:0] kidx;
  logic [KLW-1:0] klen;
  logic [1:0]     bcnt;
  logic [31:0]    work, cipher, buf_d;
  logic           buf_v, buf_last, work_last, ien, last_sel;
  logic           init_d, perm_d, sub_d, full_d, empty_f, irq_p, ctx_b;

  wire running  = (st == S_INIT) || (st == S_PERM) || (st == S_MSG);
  wire ctx_s    = addr[AW-1:8] == A_CTX[AW-1:8];
  wire ctx_acc  = (wr_en || rd_en) && (ctx_s || addr == A_IJ);
  wire klen_ok  = (wr_data >= 32'd1) && (wr_data <= 32'(KEY_MAX));
  wire klen_go  = wr_en && addr == A_KLEN && st == S_KEYW && klen_ok;
  wire msg_go   = wr_en && addr == A_MSG && (st == S_MSGW || st == S_MSG) && !buf_v;
  wire take     = (st == S_MSGW) && buf_v;
  wire key_wr   = wr_en && ((addr >= A_KEY && addr < A_KEY + AW'(KWORDS)) || addr == A_KLEN);
  wire rd_stat  = rd_en && addr == A_STAT;
  wire rd_ciph  = rd_en && addr == A_CIPH;

  wire [7:0] ia = (st == S_MSG) ? i + 8'd1 : i;
  wire [7:0] sa = s[ia];
  wire [7:0] kb = (st == S_PERM) ? key_b[kidx] : 8'd0;
  wire [7:0] jb = j + sa + kb;
  wire [7:0] sb = s[jb];
  wire [7:0] t  = sa + sb;
  wire [7:0] ks = (t == ia) ? sb : (t == jb) ? sa : s[t];
  wire [31:0] next_work = {work[7:0] ^ ks, work[31:8]};

  wire init_fin  = (st == S_INIT) && i == 8'hFF;
  wire perm_fin  = (st == S_PERM) && i == 8'hFF;
  wire sub_fin   = (st == S_MSG) && bcnt == 2'd3;
  wire full_fin  = sub_fin && work_last;
  wire fin_any   = init_fin || perm_fin || sub_fin || full_fin;

  wire [6:0] stat = {empty_f, full_d, sub_d, perm_d, init_d, irq_p, running || ctx_b};
  assign irq = irq_p && ien;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_BOOT; i <= '0; j <= '0; kidx <= '0; klen <= '0; bcnt <= '0;
      work <= '0; cipher <= '0; work_last <= 1'b0;
    end else begin
      case (st)
        S_BOOT: begin st <= S_INIT; i <= '0; end
        S_INIT: begin
          i <= i + 8'd1;
          if (init_fin) begin st <= S_KEYW; j <= '0; end
        end
        S_KEYW: if (klen_go) begin
          st <= S_PERM; klen <= wr_data[KLW-1:0]; i <= '0; j <= '0; kidx <= '0;
        end
        S_PERM: begin
          i <= i + 8'd1;
          j <= jb;
          kidx <= (KLW'(kidx) == klen - 1'b1) ? '0 : kidx + 1'b1;
          if (perm_fin) begin st <= S_MSGW; j <= '0; end
        end
        S_MSGW: if (take) begin
          st <= S_MSG; work <= buf_d; work_last <= buf_last; bcnt <= '0;
        end
        S_MSG: begin
          i <= ia; j <= jb; work <= next_work; bcnt <= bcnt + 2'd1;
          if (sub_fin) begin
            cipher <= next_work;
            st <= work_last ? S_INIT : S_MSGW;
            if (work_last) begin i <= '0; j <= '0; end
          end
        end
        default: st <= S_BOOT;
      endcase
      if (wr_en && addr == A_IJ && !running) begin
        i <= wr_data[15:8]; j <= wr_data[7:0];
      end
    end

  always_ff @(posedge clk)
    if (st == S_INIT) s[i] <= i;
    else if (st == S_PERM || st == S_MSG) begin
      s[ia] <= sb;
      s[jb] <= sa;
    end else if (wr_en && ctx_s) s[addr[7:0]] <= wr_data[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) for (int k = 0; k < KEY_MAX; k++) key_b[k] <= '0;
    else for (int k = 0; k < KEY_MAX; k++)
      if (wr_en && addr == A_KEY + AW'(k / 4)) key_b[k] <= wr_data[8*(k%4) +: 8];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      buf_v <= 1'b0; buf_d <= '0; buf_last <= 1'b0; ien <= 1'b0; last_sel <= 1'b0;
      init_d <= 1'b0; perm_d <= 1'b0; sub_d <= 1'b0; full_d <= 1'b0;
      empty_f <= 1'b0; irq_p <= 1'b0; ctx_b <= 1'b0;
    end else begin
      if (msg_go) begin buf_v <= 1'b1; buf_d <= wr_data; buf_last <= last_sel; end
      else if (take) buf_v <= 1'b0;
      if (wr_en && addr == A_CTRL) begin ien <= wr_data[0]; last_sel <= wr_data[1]; end
      if (init_fin) init_d <= 1'b1; else if (klen_go) init_d <= 1'b0;
      if (perm_fin) perm_d <= 1'b1; else if (msg_go) perm_d <= 1'b0;
      if (sub_fin)  sub_d  <= 1'b1; else if (msg_go) sub_d  <= 1'b0;
      if (full_fin) full_d <= 1'b1; else if (rd_ciph || key_wr) full_d <= 1'b0;
      if (perm_fin || take) empty_f <= 1'b1; else if (msg_go) empty_f <= 1'b0;
      if (fin_any) irq_p <= 1'b1; else if (rd_stat) irq_p <= 1'b0;
      ctx_b <= ctx_acc;
    end

  always_comb begin
    rd_data = '0;
    if (addr == A_CTRL)      rd_data = {30'd0, last_sel, ien};
    else if (addr == A_STAT) rd_data = {25'd0, stat};
    else if (addr == A_KLEN) rd_data = 32'(klen);
    else if (addr == A_CIPH) rd_data = cipher;
    else if (addr == A_IJ)   rd_data = {16'd0, i, j};
    else if (ctx_s)          rd_data = {24'd0, s[addr[7:0]]};
  end
endmodule

// File: rtl/rc4_unit_chk.sv
`timescale 1ns/1ps
module rc4_unit_chk #(
  parameter int AW      = 11,
  parameter int KEY_MAX = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [31:0]   wr_data,
  input logic          rd_en,
  input logic [31:0]   rd_data,
  input logic          irq,
  input logic [6:0]    stat,
  input logic          ien,
  input logic          fin_any,
  input logic          full_fin
);
  localparam logic [AW-1:0] C_STAT = AW'('h401);
  localparam logic [AW-1:0] C_KLEN = AW'('h404);
  localparam logic [AW-1:0] C_CIPH = AW'('h40C);
  localparam logic [AW-1:0] C_CTX  = AW'('h500);

  assert_stat_rsvd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == C_STAT) |-> rd_data[31:7] == 25'd0);

  assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien && stat[1]));

  assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fin_any |=> stat[1]);

  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == C_STAT && !fin_any) |=> !stat[1]);

  assert_klen_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[2] && wr_en && addr == C_KLEN && wr_data >= 32'd1 && wr_data <= 32'(KEY_MAX))
    |=> (!stat[2] && stat[0]));

  assert_ctx_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && addr[AW-1:8] == C_CTX[AW-1:8]) |=> stat[0]);

  assert_full_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[5] && rd_en && addr == C_CIPH && !full_fin) |=> !stat[5]);
endmodule

bind rc4_unit rc4_unit_chk #(.AW(AW), .KEY_MAX(KEY_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .irq(irq), .stat(stat), .ien(ien),
  .fin_any(fin_any), .full_fin(full_fin)
);

// File: tb/rc4_unit_bench.sv
`timescale 1ns/1ps
module rc4_unit_bench;
  localparam logic [10:0] A_CTRL = 11'h400, A_STAT = 11'h401, A_KLEN = 11'h404;
  localparam logic [10:0] A_MSG = 11'h408, A_CIPH = 11'h40C, A_KEY = 11'h410;
  localparam logic [10:0] A_CTX = 11'h500, A_IJ = 11'h600;
  localparam int NV = 4;
  localparam logic [127:0] V_KEY [NV] = '{
    128'h0079654B,
    128'h0F0E0D0C_0B0A0908_07060504_03020100,
    128'hFF,
    128'h11_E1C2A3B4};
  localparam int V_KL [NV] = '{3, 16, 1, 5};
  localparam logic [63:0] V_PT [NV] = '{
    64'h7865746E_69616C50, 64'h0, 64'hFFFFFFFF_FFFFFFFF, 64'hDEADBEEF_01234567};
  localparam logic [63:0] KNOWN0 = 64'h0AAF40D9_E816F3BB;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [10:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic irq;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rc4_unit u_rc4_unit (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [31:0] v);
    addr = a; rd_en = 1'b1; #1 v = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [10:0] a, output logic [31:0] v);
    addr = a; #1 v = rd_data;
  endtask

  task automatic poll(input int idx, input string req, output logic [31:0] v);
    for (int n = 0; n < 3000; n++) begin
      rd(A_STAT, v);
      if (v[idx]) return;
    end
    chk(req, v[idx], 1'b1);
  endtask

  function automatic logic [63:0] rc4_ref(input logic [127:0] k, input int kl, input logic [63:0] pt);
    logic [7:0] s [256];
    logic [7:0] i, j, t, tmp;
    logic [63:0] r;
    for (int n = 0; n < 256; n++) s[n] = 8'(n);
    j = 0;
    for (int n = 0; n < 256; n++) begin
      j = j + s[n] + k[8*(n%kl) +: 8];
      tmp = s[n]; s[n] = s[j]; s[j] = tmp;
    end
    i = 0; j = 0; r = '0;
    for (int n = 0; n < 8; n++) begin
      i = i + 1; j = j + s[i];
      tmp = s[i]; s[i] = s[j]; s[j] = tmp;
      t = s[i] + s[j];
      r[8*n +: 8] = pt[8*n +: 8] ^ s[t];
    end
    return r;
  endfunction

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    logic [31:0] v, c0, c1;
    logic [63:0] exp;
    repeat (3) @(negedge clk);
    peek(A_STAT, v); chk("R1 status in reset", v, 32'h0);
    rst_n = 1'b1;
    repeat (256) @(negedge clk);
    peek(A_STAT, v);
    chk("R2 busy during init", v[0], 1'b1);
    chk("R2 init done not yet", v[2], 1'b0);
    @(negedge clk);
    peek(A_STAT, v);
    chk("R2 init done, idle", v[2:0], 3'b110);
    chk("R9 irq masked after reset", irq, 1'b0);
    rd(A_CTX + 11'd200, v); chk("R2 identity S[200]", v, 32'd200);
    peek(A_STAT, v); chk("R10 busy after context read", v[0], 1'b1);
    rd(A_CTX + 11'd0, v); chk("R2 identity S[0]", v, 32'd0);
    wr(A_CTX + 11'd7, 32'h5A); rd(A_CTX + 11'd7, v); chk("R10 context write", v, 32'h5A);
    wr(A_CTX + 11'd7, 32'h07);
    wr(A_IJ, 32'h0304); rd(A_IJ, v); chk("R10 index write", v, 32'h0304);
    wr(A_IJ, 32'h0);
    wr(A_KLEN, 32'd0);  peek(A_STAT, v); chk("R3 length 0 ignored", v[2:0], 3'b110);
    wr(A_KLEN, 32'd17); peek(A_STAT, v); chk("R3 length 17 ignored", v[2:0], 3'b110);
    wr(A_CTRL, 32'h1); chk("R9 irq enabled", irq, 1'b1);
    rd(A_STAT, v); peek(A_STAT, v);
    chk("R8 pending cleared by read", v[1], 1'b0);
    chk("R9 irq low after clear", irq, 1'b0);

    for (int vi = 0; vi < NV; vi++) begin
      exp = rc4_ref(V_KEY[vi], V_KL[vi], V_PT[vi]);
      if (vi == 0) chk("R5 reference model", exp[31:0], KNOWN0[31:0]);
      if (vi > 0) begin
        poll(2, "R7 reinit done", v);
        chk("R7 init done after last word", v[2], 1'b1);
      end
      for (int w = 0; w < 4; w++) wr(A_KEY + 11'(w), V_KEY[vi][32*w +: 32]);
      wr(A_KLEN, 32'(V_KL[vi]));
      peek(A_STAT, v);
      chk("R3 permute started", {v[2], v[0]}, 2'b01);
      poll(3, "R3 permute done", v);
      wr(A_CTRL, 32'h1);
      wr(A_MSG, V_PT[vi][31:0]);
      peek(A_STAT, v);
      chk("R4 buffer full, permute done cleared", {v[6], v[3]}, 2'b00);
      poll(4, "R6 sub done", v);
      chk("R8 set wins over status read", v[1], 1'b1);
      chk("R4 buffer empty again", v[6], 1'b1);
      rd(A_CIPH, c0);
      chk("R5 cipher word 0", c0, exp[31:0]);
      wr(A_CTRL, 32'h3);
      wr(A_MSG, V_PT[vi][63:32]);
      poll(5, "R6 full done", v);
      chk("R6 sub done with last word", v[4], 1'b1);
      rd(A_CIPH, c1);
      chk("R5 cipher word 1", c1, exp[63:32]);
      peek(A_STAT, v);
      chk("R6 full done cleared by cipher read", v[5], 1'b0);
    end
    report();
  end
endmodule